// File: doc/BRIEF.md
# Ripple-Slice Integer ALU

This block is a registered integer arithmetic logic unit for a simple load/store datapath. Two operands of `WIDTH` bits (32 by default) and a 3-bit operation code go in. One clock edge later the unit returns a result word, a flag that is set when that word is all zeros, and a signed-overflow flag. The zero flag is what an equal or not-equal branch tests after a subtract.

The datapath is a chain of identical one-bit slices with a ripple carry. Each slice forms the AND, the OR and the full-adder sum of its operand bits, and a four-way multiplexer picks one of them or a "less" input. The top slice has extra logic. It detects signed overflow and forms the corrected sign of `a - b`, and that sign is routed back to the "less" input of bit 0. This is how set-on-less-than is built. The top bit of the op code does two jobs: it inverts operand B in every slice and it drives the carry into bit 0. As a result, a subtract is an add of `a + ~b + 1`.

Top module: `slice_alu`

## Requirements
- R1: Op code 000 returns the bitwise AND of the operands, and op code 001 returns the bitwise OR.
- R2: Op code 010 returns `a + b` modulo 2^WIDTH.
- R3: Op code 110 returns `a - b` modulo 2^WIDTH, formed as `a + ~b + 1`. Op bit 2 inverts B and supplies the carry-in, and op bits 1:0 select the slice output (00 AND, 01 OR, 10 sum, 11 less).
- R4: Op code 111 returns 1 in bit 0 when `a < b` as signed two's-complement values, otherwise 0. All other result bits are 0. The answer is correct even when `a - b` overflows.
- R5: `zero_o` is 1 exactly when all bits of `result_o` are 0.
- R6: For op code 010, `ovf_o` is 1 when two non-negative operands give a negative sum or two negative operands give a non-negative sum. For op code 110, it is 1 when a non-negative minus a negative gives a negative, or a negative minus a non-negative gives a non-negative. For every other op code, `ovf_o` is 0.
- R7: The unused op codes 011, 100 and 101 return a result of 0, with `zero_o` = 1 and `ovf_o` = 0.
- R8: All outputs are registered and reflect the inputs present at the previous rising clock edge. A synchronous active-high reset sets `result_o` to 0, `zero_o` to 1 and `ovf_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Registered all-zero flag of the result |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The result and both flags come from one register stage, so each is due at the first rising edge after the op code and operands are applied. The bench changes the inputs on a falling edge and samples all three outputs on the next falling edge, half a cycle after the capturing rising edge. It holds one vector per cycle, so every sample belongs to exactly one stimulus. The reset values are sampled the same way, on the falling edge that follows a rising edge with reset held high.

// File: rtl/slice_alu_pkg.sv
`timescale 1ns/1ps
package slice_alu_pkg;

  // Op code: bit 2 = invert B and carry into bit 0, bits 1:0 = slice output select.
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic op_defined(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction

  function automatic logic op_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
  import slice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       binv_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       cout_o
);
  logic b_eff;
  logic sum;

  always_comb begin
    b_eff  = b_i ^ binv_i;
    sum    = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    unique case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
`timescale 1ns/1ps
module alu_msb_slice
  import slice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       binv_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       ovf_o,
  output logic       set_o
);
  logic top_sum;

  alu_bit_slice u_slice (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .binv_i (binv_i),
    .less_i (less_i),
    .sel_i  (sel_i),
    .res_o  (res_o),
    .cout_o (cout_o)
  );

  always_comb begin
    top_sum = a_i ^ b_i ^ binv_i ^ cin_i;
    ovf_o   = cin_i ^ cout_o;
    // The true sign of the difference is the raw sign corrected by overflow.
    set_o   = top_sum ^ ovf_o;
  end
endmodule

// File: rtl/alu_slice_array.sv
`timescale 1ns/1ps
module alu_slice_array #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_bit;

  assign carry[0] = op_i[2];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_msb (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .cin_i  (carry[i]),
        .binv_i (op_i[2]),
        .less_i (1'b0),
        .sel_i  (op_i[1:0]),
        .res_o  (res_o[i]),
        .cout_o (carry[i+1]),
        .ovf_o  (ovf_o),
        .set_o  (set_bit)
      );
    end else begin : g_low
      alu_bit_slice u_bit (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .cin_i  (carry[i]),
        .binv_i (op_i[2]),
        .less_i ((i == 0) ? set_bit : 1'b0),
        .sel_i  (op_i[1:0]),
        .res_o  (res_o[i]),
        .cout_o (carry[i+1])
      );
    end
  end
endmodule

// File: rtl/slice_alu.sv
`timescale 1ns/1ps
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] raw_res;
  logic             raw_ovf;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_ovf;

  alu_slice_array #(.WIDTH(WIDTH)) u_array (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (raw_res),
    .ovf_o (raw_ovf)
  );

  always_comb begin
    nxt_res = op_defined(op_i) ? raw_res : '0;
    nxt_ovf = op_arith(op_i) & raw_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= nxt_res;
      zero_o   <= (nxt_res == '0);
      ovf_o    <= nxt_ovf;
    end
  end

  // Marks a cycle whose predecessor was out of reset, so $past inputs are meaningful.
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  p_and_r1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OP_AND) |-> result_o == ($past(a_i) & $past(b_i)));

  p_add_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OP_ADD) |-> result_o == WIDTH'($past(a_i) + $past(b_i)));

  p_sub_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OP_SUB) |-> result_o == WIDTH'($past(a_i) - $past(b_i)));

  p_slt_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_i) == OP_SLT) |->
      result_o == WIDTH'($signed($past(a_i)) < $signed($past(b_i))));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !op_arith($past(op_i))) |-> !ovf_o);

  p_unused_op_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !op_defined($past(op_i))) |-> (result_o == '0 && zero_o));

  p_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && zero_o && !ovf_o));
endmodule

// File: tb/slice_alu_tb_top.sv
`timescale 1ns/1ps
module slice_alu_tb_top;
  localparam int WS = 4;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op  = 3'b000;
  logic [WS-1:0] a_s = '0, b_s = '0;
  logic [WW-1:0] a_w = '0, b_w = '0;
  logic [WS-1:0] r_s;
  logic [WW-1:0] r_w;
  logic          z_s, o_s, z_w, o_w;

  int  vectors = 0;
  int  misses  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  slice_alu #(.WIDTH(WS)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a_s), .b_i(b_s),
    .result_o(r_s), .zero_o(z_s), .ovf_o(o_s));

  slice_alu #(.WIDTH(WW)) dut_w_i (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a_w), .b_i(b_w),
    .result_o(r_w), .zero_o(z_w), .ovf_o(o_w));

  function automatic string req_tag(input logic [2:0] o);
    case (o)
      3'b000, 3'b001: return "R1";
      3'b010:         return "R2";
      3'b110:         return "R3";
      3'b111:         return "R4";
      default:        return "R7";
    endcase
  endfunction

  task automatic model(input int w, input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] r,
                       output logic z, output logic v);
    logic [31:0] mask;
    longint sa, sb, t, lo, hi;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
    lo = -(longint'(1) << (w-1));
    hi = (longint'(1) << (w-1)) - 1;
    v = 1'b0;
    case (o)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin r = (a + b) & mask; t = sa + sb; v = (t < lo) || (t > hi); end
      3'b110: begin r = (a - b) & mask; t = sa - sb; v = (t < lo) || (t > hi); end
      3'b111: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
    r = r & mask;
    z = (r == 32'd0);
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s op=%b actual=%h expected=%h", tag, what, op, act, exp);
    end
  endtask

  // R8: inputs go in on a falling edge, outputs are sampled one full cycle later.
  task automatic apply(input logic [2:0] o, input logic [WS-1:0] as, input logic [WS-1:0] bs,
                       input logic [WW-1:0] aw, input logic [WW-1:0] bw);
    logic [31:0] er;
    logic ez, ev;
    @(negedge clk);
    op = o; a_s = as; b_s = bs; a_w = aw; b_w = bw;
    @(negedge clk);
    vectors++;
    model(WS, o, 32'(as), 32'(bs), er, ez, ev);
    check(req_tag(o), "small result", 32'(r_s), er);
    check("R5", "small zero", 32'(z_s), 32'(ez));
    check("R6", "small ovf", 32'(o_s), 32'(ev));
    model(WW, o, aw, bw, er, ez, ev);
    check(req_tag(o), "wide result", r_w, er);
    check("R5", "wide zero", 32'(z_w), 32'(ez));
    check("R6", "wide ovf", 32'(o_w), 32'(ev));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [8];
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h8000_0001;
    corners[6] = 32'h7FFF_FFFE; corners[7] = 32'h5555_AAAA;

    // R8: reset values, sampled after reset-held rising edges.
    op = 3'b010; a_s = 4'hF; b_s = 4'h1; a_w = 32'hFFFF_FFFF; b_w = 32'h1;
    repeat (3) @(negedge clk);
    vectors++;
    check("R8", "reset result small", 32'(r_s), 32'd0);
    check("R8", "reset result wide", r_w, 32'd0);
    check("R8", "reset zero", {30'd0, z_s, z_w}, 32'd3);
    check("R8", "reset ovf", {30'd0, o_s, o_w}, 32'd0);
    rst = 1'b0;

    // Exhaustive sweep of every op code on the 4-bit unit; hashed operands on the wide one.
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          int k;
          k = (o << 8) | (a << 4) | b;
          apply(3'(o), 4'(a), 4'(b), 32'(k) * 32'h9E37_79B9, (32'(k) * 32'h85EB_CA6B) ^ 32'h00FF_00F0);
        end

    // Signed corners on the wide unit: overflow on add/sub, SLT across overflow (R4, R6).
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(3'(o), 4'(i), 4'(j), corners[i], corners[j]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule